// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the processor-facing register file of a FIFO-buffered serial port. A host reaches it over an 8-bit data bus with a 3-bit byte address and separate read and write strobes. Eight offsets are decoded. Bit 7 of the line control register acts as a bank select that swaps the two lowest offsets between the data port and interrupt enable, and the two bytes of a 16-bit baud divisor.

The block keeps the reset values and the control registers. It also carries out the side effects of each access. A data read pops the receive FIFO and a data write pushes the transmit FIFO. A status read clears the sticky flags, and a FIFO control write produces flush pulses. The shifters, the FIFOs, the baud generator and the interrupt arbiter sit outside. They exchange single-cycle strobes and level status with this bank. The divisor reaches the baud generator through a shadow copy that changes only on a baud tick, so a new rate starts on a period boundary.

Top module: `uart_regfile`

## Requirements
- R1: With the line inputs idle (thr_empty=1, tx_idle=1, int_id=4'b0001, the other status inputs 0), the values read after reset are: line control 0x00, interrupt enable 0x00, modem control 0x00, scratch 0x00, both divisor bytes 0x00, modem status 0x00, line status 0x60 and identification 0xC1. The divisor output is 0.
- R2: The offsets are 0 data or divisor low, 1 interrupt enable or divisor high, 2 identification on read and FIFO control on write, 3 line control, 4 modem control, 5 line status, 6 modem status and 7 scratch. Line control bit 7 (0x80) set selects the divisor bytes at offsets 0 and 1.
- R3: bus_rdata takes the addressed value at the clock edge that samples bus_rd, and it holds that value until the next read.
- R4: The scratch register returns any byte written to it, including 0x00 and 0xFF.
- R5: Line control reads back all 8 bits last written, and line_ctrl carries the same value.
- R6: With the bank bit clear, a read of offset 0 returns rx_data and rx_pop is high for exactly the one cycle after the read. With the bank bit set, the read returns the divisor low byte and rx_pop stays low.
- R7: With the bank bit clear, a write to offset 0 raises tx_push for the one cycle after it, with tx_data equal to the written byte. With the bank bit set, the write loads the divisor low byte and tx_push stays low. Offset 1 loads the divisor high byte when the bank bit is set, and interrupt enable otherwise.
- R8: A read of offset 2 returns {2'b11, 2'b00, int_id}. A write to offset 2 gives a one-cycle rx_flush pulse if bit 1 is set and a one-cycle tx_flush pulse if bit 2 is set, and loads rx_trig from bits 7:6. The value read at offset 2 is unchanged by the write.
- R9: Line status reads {rx_fifo_err, tx_idle, thr_empty, break, framing, parity, overrun, rx_ready}. The four error flags latch on err_set[3:0] (bit 0 overrun through bit 3 break). A line status read returns the flags and then clears them, but an error set in the same cycle as the read is kept.
- R10: Modem status reads {line levels, change flags}. The upper nibble is the registered modem_lines value. Bit i of the lower nibble sets when modem_lines[i] differs from its registered level, and it clears on a read of offset 6.
- R11: The divisor output copies {high, low} on a cycle with baud_tick high. While the output is zero it copies on every cycle. Otherwise it holds.
- R12: Interrupt enable keeps the low 4 bits and modem control keeps the low 5 bits. Both read their upper bits as 0, and int_en and modem_ctrl carry the stored values.
- R13: Writes to offsets 5 and 6 change neither register, and they do not clear latched line errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Head of receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop pulse |
| tx_data | output | 8 | Byte for transmit FIFO |
| tx_push | output | 1 | Transmit FIFO push pulse |
| rx_flush | output | 1 | Empty receive FIFO pulse |
| tx_flush | output | 1 | Empty transmit FIFO pulse |
| rx_trig | output | 2 | Receive trigger level field |
| line_ctrl | output | 8 | Line control value |
| int_en | output | 4 | Interrupt enable bits |
| modem_ctrl | output | 5 | Modem control bits |
| int_id | input | 4 | Identification code from interrupt arbiter |
| rx_ready | input | 1 | Receive data available |
| thr_empty | input | 1 | Transmit holding space empty |
| tx_idle | input | 1 | Transmitter fully idle |
| rx_fifo_err | input | 1 | Error byte present in receive FIFO |
| err_set | input | 4 | Error event strobes: overrun, parity, framing, break |
| modem_lines | input | 4 | Modem input line levels |
| baud_tick | input | 1 | Baud period boundary strobe |
| divisor | output | 16 | Active baud divisor |

## Verification
The assertions assume that bus_rd and bus_wr never rise in the same cycle, since a read and a write to one register at once have no defined order. They also assume that err_set and baud_tick are single-cycle events. The stimulus keeps to this: every bus access goes through one task that raises a single strobe for a single cycle. Status and tick inputs change only on the falling edge, away from the sampling edge. The cases that need two things in one cycle, such as an error arriving during a status read, are driven on their own without breaking these assumptions.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFS_W    = 3;
  localparam int unsigned ERR_W    = 4;
  localparam int unsigned MLINE_W  = 4;
  localparam int unsigned ID_W     = 4;
  localparam int unsigned BANK_BIT = 7;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IDENT = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ERR_W-1:0]  err_set,
  input  logic              clr,
  input  logic              rx_ready,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              rx_fifo_err,
  output logic [BYTE_W-1:0] status
);
  logic [ERR_W-1:0] err_q;

  // Set has priority over the read-clear so no event is lost.
  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (clr ? '0 : err_q) | err_set;
  end

  assign status = {rx_fifo_err, tx_idle, thr_empty, err_q, rx_ready};

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q))); // R9
  AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set))); // R9
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MLINE_W-1:0]   lines,
  input  logic                 clr,
  output logic [2*MLINE_W-1:0] status
);
  logic [MLINE_W-1:0] lvl_q;
  logic [MLINE_W-1:0] chg_q;

  for (genvar i = 0; i < MLINE_W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[i] <= 1'b0;
        chg_q[i] <= 1'b0;
      end else begin
        lvl_q[i] <= lines[i];
        chg_q[i] <= (clr ? 1'b0 : chg_q[i]) | (lines[i] ^ lvl_q[i]);
      end
    end
  end

  assign status = {lvl_q, chg_q};

  AST_DELTA_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (lines != lvl_q) |=> (chg_q != '0)); // R10
endmodule

// File: rtl/uart_divisor_latch.sv
module uart_divisor_latch #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic          baud_tick,
  output logic [BW-1:0] lat_lo,
  output logic [BW-1:0] lat_hi,
  output logic [2*BW-1:0] divisor
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_lo  <= '0;
      lat_hi  <= '0;
      divisor <= '0;
    end else begin
      if (wr_lo) lat_lo <= wdata;
      if (wr_hi) lat_hi <= wdata;
      // A stopped generator (zero divisor) never ticks, so reload freely then.
      if (baud_tick || (divisor == '0)) divisor <= {lat_hi, lat_lo};
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!baud_tick && (divisor != '0)) |=> $stable(divisor)); // R11
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int unsigned IEN_W  = 4,
  parameter int unsigned MCTL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic [7:0]        tx_data,
  output logic              tx_push,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic [1:0]        rx_trig,
  output logic [7:0]        line_ctrl,
  output logic [IEN_W-1:0]  int_en,
  output logic [MCTL_W-1:0] modem_ctrl,
  input  logic [3:0]        int_id,
  input  logic              rx_ready,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              rx_fifo_err,
  input  logic [3:0]        err_set,
  input  logic [3:0]        modem_lines,
  input  logic              baud_tick,
  output logic [15:0]       divisor
);
  localparam logic [1:0] FIFO_FLAGS = 2'b11;

  reg_ofs_e          ofs;
  logic              bank;
  logic [BYTE_W-1:0] scr_q;
  logic [BYTE_W-1:0] div_lo, div_hi;
  logic [BYTE_W-1:0] lsr_val, msr_val;
  logic [BYTE_W-1:0] rd_mux;
  logic              wr_div_lo, wr_div_hi, rd_data_hit, lsr_clr, msr_clr;

  assign ofs         = reg_ofs_e'(bus_addr);
  assign bank        = line_ctrl[BANK_BIT];
  assign wr_div_lo   = bus_wr && (ofs == OFS_DATA) && bank;
  assign wr_div_hi   = bus_wr && (ofs == OFS_IEN) && bank;
  assign rd_data_hit = bus_rd && (ofs == OFS_DATA) && !bank;
  assign lsr_clr     = bus_rd && (ofs == OFS_LSTAT);
  assign msr_clr     = bus_rd && (ofs == OFS_MSTAT);

  uart_line_status u_lsr (
    .clk(clk), .rst(rst), .err_set(err_set), .clr(lsr_clr),
    .rx_ready(rx_ready), .thr_empty(thr_empty), .tx_idle(tx_idle),
    .rx_fifo_err(rx_fifo_err), .status(lsr_val)
  );

  uart_modem_status u_msr (
    .clk(clk), .rst(rst), .lines(modem_lines), .clr(msr_clr), .status(msr_val)
  );

  uart_divisor_latch #(.BW(BYTE_W)) u_div (
    .clk(clk), .rst(rst), .wr_lo(wr_div_lo), .wr_hi(wr_div_hi),
    .wdata(bus_wdata), .baud_tick(baud_tick),
    .lat_lo(div_lo), .lat_hi(div_hi), .divisor(divisor)
  );

  always_comb begin
    case (ofs)
      OFS_DATA:  rd_mux = bank ? div_lo : rx_data;
      OFS_IEN:   rd_mux = bank ? div_hi : BYTE_W'(int_en);
      OFS_IDENT: rd_mux = {FIFO_FLAGS, 2'b00, int_id};
      OFS_LCTL:  rd_mux = line_ctrl;
      OFS_MCTL:  rd_mux = BYTE_W'(modem_ctrl);
      OFS_LSTAT: rd_mux = lsr_val;
      OFS_MSTAT: rd_mux = msr_val;
      OFS_SCR:   rd_mux = scr_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_ctrl  <= '0;
      int_en     <= '0;
      modem_ctrl <= '0;
      scr_q      <= '0;
      rx_trig    <= '0;
      tx_data    <= '0;
      tx_push    <= 1'b0;
      rx_pop     <= 1'b0;
      rx_flush   <= 1'b0;
      tx_flush   <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      tx_push  <= 1'b0;
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
      rx_pop   <= rd_data_hit;
      if (bus_wr) begin
        case (ofs)
          OFS_DATA: if (!bank) begin
            tx_push <= 1'b1;
            tx_data <= bus_wdata;
          end
          OFS_IEN:  if (!bank) int_en <= bus_wdata[IEN_W-1:0];
          OFS_IDENT: begin
            rx_flush <= bus_wdata[1];
            tx_flush <= bus_wdata[2];
            rx_trig  <= bus_wdata[7:6];
          end
          OFS_LCTL: line_ctrl  <= bus_wdata;
          OFS_MCTL: modem_ctrl <= bus_wdata[MCTL_W-1:0];
          OFS_SCR:  scr_q      <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R3
  AST_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == 3'd7)) |=> $stable(scr_q)); // R4
  AST_POP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> ($past(bus_rd) && ($past(bus_addr) == 3'd0) && !$past(line_ctrl[7]))); // R6
  AST_PUSH_VALUE: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> ((tx_data == $past(bus_wdata)) && !$past(line_ctrl[7]))); // R7
  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (rx_flush || tx_flush) |-> ($past(bus_wr) && ($past(bus_addr) == 3'd2))); // R8
endmodule

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] rx_data = '0;
  logic rx_pop, tx_push, rx_flush, tx_flush;
  logic [7:0] tx_data, line_ctrl;
  logic [1:0] rx_trig;
  logic [3:0] int_en;
  logic [4:0] modem_ctrl;
  logic [3:0] int_id = 4'b0001;
  logic rx_ready = 1'b0, thr_empty = 1'b1, tx_idle = 1'b1, rx_fifo_err = 1'b0;
  logic [3:0] err_set = '0;
  logic [3:0] modem_lines = '0;
  logic baud_tick = 1'b0;
  logic [15:0] divisor;

  always #2 clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .rx_trig(rx_trig),
    .line_ctrl(line_ctrl), .int_en(int_en), .modem_ctrl(modem_ctrl),
    .int_id(int_id), .rx_ready(rx_ready), .thr_empty(thr_empty),
    .tx_idle(tx_idle), .rx_fifo_err(rx_fifo_err), .err_set(err_set),
    .modem_lines(modem_lines), .baud_tick(baud_tick), .divisor(divisor)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_pending = 1'b0;

  always @(posedge clk) rd_pending <= bus_rd;

  // Monitor: compares each registered read result with the scoreboard head.
  always @(negedge clk) begin
    if (rd_pending && !rst) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL read without expectation: actual %02h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %04h expected %04h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(3'd3, 8'h00, "R1 line control");
    rd(3'd1, 8'h00, "R1 interrupt enable");
    rd(3'd4, 8'h00, "R1 modem control");
    rd(3'd7, 8'h00, "R1 scratch");
    rd(3'd5, 8'h60, "R1 line status");
    rd(3'd6, 8'h00, "R1 modem status");
    rd(3'd2, 8'hC1, "R1 identification");
    chk("R1 divisor output", divisor, 16'h0000);
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h00, "R1 divisor low");
    chk("R6 no pop in divisor bank", {15'd0, rx_pop}, 16'd0);
    rd(3'd1, 8'h00, "R1 divisor high");
    wr(3'd3, 8'h00);

    // R4 scratch
    wr(3'd7, 8'h00); rd(3'd7, 8'h00, "R4 scratch zero");
    wr(3'd7, 8'hFF); rd(3'd7, 8'hFF, "R4 scratch ones");
    for (int i = 0; i < 16; i++) begin
      logic [15:0] sh;
      sh = 16'hDEAD << i;
      wr(3'd7, sh[7:0]);
      rd(3'd7, sh[7:0], "R4 scratch pattern");
    end

    // R5 line control readback
    begin
      logic [7:0] lv[5] = '{8'h03, 8'h07, 8'h5A, 8'h3F, 8'h1B};
      for (int i = 0; i < 5; i++) begin
        wr(3'd3, lv[i]);
        chk("R5 line_ctrl port", {8'd0, line_ctrl}, {8'd0, lv[i]});
        rd(3'd3, lv[i], "R5 line control readback");
      end
    end
    wr(3'd3, 8'h03);

    // R12 enable and modem control widths
    wr(3'd1, 8'hFF); rd(3'd1, 8'h0F, "R12 interrupt enable mask");
    chk("R12 int_en port", {12'd0, int_en}, 16'h000F);
    wr(3'd4, 8'hFF); rd(3'd4, 8'h1F, "R12 modem control mask");
    chk("R12 modem_ctrl port", {11'd0, modem_ctrl}, 16'h001F);
    wr(3'd1, 8'h05);

    // R6 data read pops
    rx_data = 8'h5A;
    rd(3'd0, 8'h5A, "R6 receive data");
    chk("R6 pop pulse", {15'd0, rx_pop}, 16'd1);
    @(negedge clk);
    chk("R6 pop single cycle", {15'd0, rx_pop}, 16'd0);

    // R3 read data holds
    bus_addr = 3'd7; rx_data = 8'h11;
    repeat (3) @(negedge clk);
    chk("R3 read data held", {8'd0, bus_rdata}, 16'h005A);

    // R7 data write pushes
    wr(3'd0, 8'hA5);
    chk("R7 push pulse", {15'd0, tx_push}, 16'd1);
    chk("R7 push data", {8'd0, tx_data}, 16'h00A5);
    @(negedge clk);
    chk("R7 push single cycle", {15'd0, tx_push}, 16'd0);
    rd(3'd1, 8'h05, "R7 enable unaffected by data write");

    // R2 / R7 / R11 divisor bank
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    chk("R7 no push in divisor bank", {15'd0, tx_push}, 16'd0);
    wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R2 divisor low");
    chk("R6 no pop in divisor bank", {15'd0, rx_pop}, 16'd0);
    rd(3'd1, 8'h12, "R2 divisor high");
    chk("R11 zero divisor reloads at once", divisor, 16'h0034);
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
    chk("R11 tick loads divisor", divisor, 16'h1234);
    wr(3'd0, 8'h56);
    repeat (4) @(negedge clk);
    chk("R11 divisor waits for tick", divisor, 16'h1234);
    baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
    chk("R11 second tick loads", divisor, 16'h1256);
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h05, "R2 bank clear shows enable");
    rd(3'd3, 8'h03, "R2 line control after bank");

    // R8 identification and FIFO control
    int_id = 4'b0100;
    rd(3'd2, 8'hC4, "R8 identification code");
    wr(3'd2, 8'hC6);
    chk("R8 rx flush", {15'd0, rx_flush}, 16'd1);
    chk("R8 tx flush", {15'd0, tx_flush}, 16'd1);
    chk("R8 trigger field", {14'd0, rx_trig}, 16'd3);
    rd(3'd2, 8'hC4, "R8 ident unchanged by control write");
    wr(3'd2, 8'h02);
    chk("R8 rx flush only", {15'd0, rx_flush}, 16'd1);
    chk("R8 no tx flush", {15'd0, tx_flush}, 16'd0);
    chk("R8 trigger cleared", {14'd0, rx_trig}, 16'd0);
    @(negedge clk);
    chk("R8 flush single cycle", {15'd0, rx_flush}, 16'd0);
    int_id = 4'b0001;

    // R9 line status
    rx_ready = 1'b1; rx_fifo_err = 1'b1;
    @(negedge clk); err_set = 4'b0101;
    @(negedge clk); err_set = 4'b0000;
    rd(3'd5, 8'hEB, "R9 status with errors");
    rx_fifo_err = 1'b0;
    rd(3'd5, 8'h61, "R9 errors cleared by read");
    @(negedge clk); err_set = 4'b0001;
    @(negedge clk); err_set = 4'b0000;
    @(negedge clk);
    exp_q.push_back(8'h63); tag_q.push_back("R9 read during new error");
    bus_addr = 3'd5; bus_rd = 1'b1; err_set = 4'b1000;
    @(negedge clk);
    bus_rd = 1'b0; err_set = 4'b0000;
    rd(3'd5, 8'h71, "R9 concurrent error kept");
    rd(3'd5, 8'h61, "R9 cleared again");

    // R13 read-only status
    rx_ready = 1'b0;
    @(negedge clk); err_set = 4'b0010;
    @(negedge clk); err_set = 4'b0000;
    wr(3'd5, 8'h00);
    wr(3'd6, 8'hFF);
    rd(3'd5, 8'h64, "R13 write keeps line errors");
    rd(3'd6, 8'h00, "R13 modem status unchanged");

    // R10 modem status
    modem_lines = 4'b0011;
    @(negedge clk);
    rd(3'd6, 8'h33, "R10 levels and changes");
    rd(3'd6, 8'h30, "R10 changes cleared");
    modem_lines = 4'b0001;
    @(negedge clk);
    rd(3'd6, 8'h12, "R10 falling line change");
    rd(3'd6, 8'h10, "R10 cleared again");

    repeat (3) @(negedge clk);
    chk("R3 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finish_run();
  end
endmodule